// File: doc/BRIEF.md
# GPIO Port with Pin Interrupts

A sixteen-pin general-purpose I/O port that sits on a synchronous register bus and faces the pads. Software sets each pin as an input, a push-pull output or an open-drain output. It writes output data through a per-pin write mask, turns pull-ups on or off, and can switch off a pin's digital input path. Every pin also has a word address of its own, so software can read or drive a single pin without a read-modify-write of the whole port.

Each pin can raise an interrupt. It can do so on a rising edge, a falling edge, both edges, a high level or a low level. The choice comes from two enable halves of one word and a per-pin trigger-type bit. The flags are cleared by writing ones to them, and a single interrupt line is the OR of all flags. Pad inputs are synchronised by two flops before any detection. A global control bit selects the detector mode. In one mode the detector keeps sampling every pin. In the other it samples only pins that have an interrupt enable set.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset every pin is an input. Output data, masks, pull-ups, input disables, enables, trigger types, the control bit and all flags are 0. pad_oe, pad_out, pad_pu and irq are 0.
- R2: Each pin has a 2-bit mode field at bits [2n+1:2n] of the mode register (offset 0x00). 0 = input: no drive. 1 = push-pull: pad_oe=1, pad_out=data. 2 = open-drain: pad_out=0, pad_oe=1 when data is 0 and 0 when data is 1. 3 is treated as input. The pad outputs change one cycle after the register write.
- R3: A write to the output data register (0x0C) updates only the pins whose bit in the mask register (0x10) is 0. Masked pins keep their value.
- R4: The word at byte 0x100 + 0x40*PORT_IDX + 4*n reads pin n's input level in bit 0. A write there sets only pin n's output data from bit 0, and this write does not use the mask.
- R5: Bit 16+n of the input-disable register (0x08) disables pin n. A disabled pin reads 0 in the input register (0x14) and in its alias, and it never sets its flag.
- R6: In edge mode (bit n of 0x1C = 0), bit 16+n of the enable register (0x18) flags rising edges of pin n and bit n flags falling edges. Both bits set flags both edges.
- R7: In level mode (bit n of 0x1C = 1), bit 16+n flags while the pin is high and bit n flags while it is low. A cleared flag sets again while the level persists.
- R8: Writing a mask to the status register (0x20) clears exactly those flags. If a new event on a pin coincides with its clear, the flag stays set.
- R9: irq is 1 exactly when at least one flag is set, and it changes on the same clock edge as the flags.
- R10: Bit 0 of the control register (0x24) set to 1 keeps edge history for every pin. Set to 0, a pin's history freezes while both its enables are 0, so a change made during that time is flagged once the pin is enabled.
- R11: After a pad change, the matching edge flag and irq are set on the third rising clock edge.
- R12: pad_pu follows the pull-up register (0x04) one cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after reg_rd |
| pad_in | input | W | Pad input levels, asynchronous |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |
| pad_pu | output | W | Pull-up enables |
| irq | output | 1 | Combined port interrupt |

## Verification
Reads return data one cycle after the strobe. A scoreboard monitor therefore compares reg_rdata at the falling edge after each read cycle, against a value that the driver queued when it issued the read. Pad drive and pull-up outputs lag a register write by one edge, so they are sampled at the second falling edge after the write strobe. A pad change is driven at a falling edge. Edge flags then appear at the third rising edge, so the bench checks that irq is still 0 one falling edge before that and 1 right after it. Other interrupt checks allow four cycles for the flag to settle before reading status.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_IN   = 2'd0,
    PM_PUSH = 2'd1,
    PM_OPEN = 2'd2,
    PM_RSVD = 2'd3
  } pin_mode_e;

  localparam int unsigned HALF_POS  = 16;
  localparam int unsigned OFS_MODE  = 'h00;
  localparam int unsigned OFS_PU    = 'h04;
  localparam int unsigned OFS_DIS   = 'h08;
  localparam int unsigned OFS_DOUT  = 'h0C;
  localparam int unsigned OFS_MASK  = 'h10;
  localparam int unsigned OFS_LEVEL = 'h14;
  localparam int unsigned OFS_IEN   = 'h18;
  localparam int unsigned OFS_TYPE  = 'h1C;
  localparam int unsigned OFS_STAT  = 'h20;
  localparam int unsigned OFS_CTL   = 'h24;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] mode_vec,
  input  logic [W-1:0]   dout,
  input  logic [W-1:0]   pu_en,
  output logic [W-1:0]   pad_out,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_mode_e md;
    assign md = pin_mode_e'(mode_vec[2*i +: 2]);

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        case (md)
          PM_PUSH: begin
            pad_out[i] <= dout[i];
            pad_oe[i]  <= 1'b1;
          end
          PM_OPEN: begin
            pad_out[i] <= 1'b0;
            pad_oe[i]  <= ~dout[i];
          end
          default: begin
            pad_out[i] <= 1'b0;
            pad_oe[i]  <= 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pad_pu <= '0;
    else     pad_pu <= pu_en;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] in_dis,
  input  logic [W-1:0] en_lo,
  input  logic [W-1:0] en_hi,
  input  logic [W-1:0] lvl_mode,
  input  logic         always_on,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] event_v;
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_nx;
  logic         irq_q;

  for (genvar i = 0; i < W; i++) begin : g_det
    logic active;
    logic rise;
    logic fall;
    assign active = always_on | en_lo[i] | en_hi[i];
    assign rise   =  level[i] & ~prev_q[i];
    assign fall   = ~level[i] &  prev_q[i];

    always_comb begin
      if (in_dis[i])
        event_v[i] = 1'b0;
      else if (lvl_mode[i])
        event_v[i] = (level[i] & en_hi[i]) | (~level[i] & en_lo[i]);
      else
        event_v[i] = (rise & en_hi[i]) | (fall & en_lo[i]);
    end

    always_ff @(posedge clk) begin
      if (rst)         prev_q[i] <= 1'b0;
      else if (active) prev_q[i] <= level[i];
    end
  end

  assign stat_nx = (stat_q & ~clr_mask) | event_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      irq_q  <= |stat_nx;
    end
  end

  assign status = stat_q;
  assign irq    = irq_q;
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_port_pkg::*;
#(
  parameter int W          = 16,
  parameter int ADDR_W     = 12,
  parameter int PORT_IDX   = 0,
  parameter int ALIAS_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pu,
  output logic              irq
);
  localparam int IDX_W    = (W > 1) ? $clog2(W) : 1;
  localparam int ALIAS_LO = ALIAS_BASE + 64 * PORT_IDX;
  localparam int ALIAS_SZ = 4 * W;

  logic [2*W-1:0] mode_q;
  logic [W-1:0]   pu_q, dis_q, dout_q, mask_q;
  logic [W-1:0]   en_lo_q, en_hi_q, type_q;
  logic           aon_q;
  logic [31:0]    rdata_q, rd_mux;

  logic [W-1:0]   sync_v, level_v, stat_vec, clr_mask;
  logic           dout_wr;
  logic           alias_hit;
  logic [ADDR_W-1:0] alias_rel;
  logic [IDX_W-1:0]  alias_idx;

  gpio_in_sync #(.W(W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pad_in),
    .d_sync  (sync_v)
  );

  assign level_v = sync_v & ~dis_q;

  assign alias_rel = reg_addr - ADDR_W'(ALIAS_LO);
  assign alias_hit = (reg_addr >= ADDR_W'(ALIAS_LO)) &&
                     (alias_rel < ADDR_W'(ALIAS_SZ));
  assign alias_idx = alias_rel[2 +: IDX_W];

  assign dout_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_DOUT));
  assign clr_mask = (reg_wr && reg_addr == ADDR_W'(OFS_STAT)) ?
                    reg_wdata[W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      pu_q    <= '0;
      dis_q   <= '0;
      dout_q  <= '0;
      mask_q  <= '0;
      en_lo_q <= '0;
      en_hi_q <= '0;
      type_q  <= '0;
      aon_q   <= 1'b0;
    end else if (reg_wr) begin
      if (alias_hit) begin
        dout_q[alias_idx] <= reg_wdata[0];
      end else begin
        case (reg_addr)
          ADDR_W'(OFS_MODE): mode_q <= reg_wdata[2*W-1:0];
          ADDR_W'(OFS_PU):   pu_q   <= reg_wdata[W-1:0];
          ADDR_W'(OFS_DIS):  dis_q  <= reg_wdata[HALF_POS +: W];
          ADDR_W'(OFS_DOUT): dout_q <= (dout_q & mask_q) |
                                       (reg_wdata[W-1:0] & ~mask_q);
          ADDR_W'(OFS_MASK): mask_q <= reg_wdata[W-1:0];
          ADDR_W'(OFS_IEN): begin
            en_lo_q <= reg_wdata[W-1:0];
            en_hi_q <= reg_wdata[HALF_POS +: W];
          end
          ADDR_W'(OFS_TYPE): type_q <= reg_wdata[W-1:0];
          ADDR_W'(OFS_CTL):  aon_q  <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (alias_hit) begin
      rd_mux[0] = level_v[alias_idx];
    end else begin
      case (reg_addr)
        ADDR_W'(OFS_MODE):  rd_mux[2*W-1:0] = mode_q;
        ADDR_W'(OFS_PU):    rd_mux[W-1:0]   = pu_q;
        ADDR_W'(OFS_DIS):   rd_mux[HALF_POS +: W] = dis_q;
        ADDR_W'(OFS_DOUT):  rd_mux[W-1:0]   = dout_q;
        ADDR_W'(OFS_MASK):  rd_mux[W-1:0]   = mask_q;
        ADDR_W'(OFS_LEVEL): rd_mux[W-1:0]   = level_v;
        ADDR_W'(OFS_IEN): begin
          rd_mux[W-1:0]         = en_lo_q;
          rd_mux[HALF_POS +: W] = en_hi_q;
        end
        ADDR_W'(OFS_TYPE):  rd_mux[W-1:0]   = type_q;
        ADDR_W'(OFS_STAT):  rd_mux[W-1:0]   = stat_vec;
        ADDR_W'(OFS_CTL):   rd_mux[0]       = aon_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end
  assign reg_rdata = rdata_q;

  gpio_pad_drive #(.W(W)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .mode_vec (mode_q),
    .dout     (dout_q),
    .pu_en    (pu_q),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu)
  );

  gpio_irq_unit #(.W(W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .level     (level_v),
    .in_dis    (dis_q),
    .en_lo     (en_lo_q),
    .en_hi     (en_hi_q),
    .lvl_mode  (type_q),
    .always_on (aon_q),
    .clr_mask  (clr_mask),
    .status    (stat_vec),
    .irq       (irq)
  );
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic         irq,
  input logic [W-1:0] status,
  input logic [W-1:0] clr_mask,
  input logic [W-1:0] dis_q,
  input logic [W-1:0] dout_q,
  input logic [W-1:0] mask_q,
  input logic         dout_wr
);
  AST_HIGH_ONLY_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0); // R2

  AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(dout_wr) |-> ((dout_q ^ $past(dout_q)) & $past(mask_q)) == '0); // R3

  AST_DISABLED_NEVER_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(status) & $past(dis_q)) == '0); // R5

  AST_FLAG_DROPS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(status) & ~status & ~$past(clr_mask)) == '0); // R8

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    irq == (status != '0)); // R9
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .irq      (irq),
  .status   (stat_vec),
  .clr_mask (clr_mask),
  .dis_q    (dis_q),
  .dout_q   (dout_q),
  .mask_q   (mask_q),
  .dout_wr  (dout_wr)
);

// File: tb/tb_gpio_port_irq.sv
module tb_gpio_port_irq;
  localparam int W = 16;
  localparam logic [11:0] A_MODE = 12'h000, A_PU = 12'h004, A_DIS = 12'h008,
    A_DOUT = 12'h00C, A_MASK = 12'h010, A_LVL = 12'h014, A_IEN = 12'h018,
    A_TYPE = 12'h01C, A_STAT = 12'h020, A_CTL = 12'h024, A_ALIAS = 12'h100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe, pad_pu;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_port_irq dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_pad(input logic [W-1:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  always @(posedge clk) rd_d <= reg_rd;

  // scoreboard monitor: compare one cycle after each read strobe
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        chk(32'hDEAD, 32'h0, "scoreboard underflow");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_rdata, e, t);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ien;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk({16'b0, pad_oe}, 32'h0, "R1 pad_oe");
    chk({16'b0, pad_out}, 32'h0, "R1 pad_out");
    chk({16'b0, pad_pu}, 32'h0, "R1 pad_pu");
    chk({31'b0, irq}, 32'h0, "R1 irq");
    rd(A_MODE, 32'h0, "R1 mode");
    rd(A_DOUT, 32'h0, "R1 dout");
    rd(A_IEN,  32'h0, "R1 ien");
    rd(A_STAT, 32'h0, "R1 status");

    // R2 modes: pin0 push, pin1 open-drain, pin2 input, pin3 reserved
    wr(A_MODE, 32'h0000_00C9);
    wr(A_DOUT, 32'h0);
    idle(1);
    chk({16'b0, pad_oe}, 32'h3, "R2 oe data0");
    chk({16'b0, pad_out}, 32'h0, "R2 out data0");
    wr(A_DOUT, 32'h000F);
    idle(1);
    chk({16'b0, pad_oe}, 32'h1, "R2 oe data1");
    chk({16'b0, pad_out}, 32'h1, "R2 out data1");
    rd(A_MODE, 32'h0000_00C9, "R2 mode readback");

    // R3 masked write
    wr(A_MASK, 32'h0001);
    wr(A_DOUT, 32'h0);
    rd(A_DOUT, 32'h0001, "R3 masked dout");
    idle(1);
    chk({16'b0, pad_out}, 32'h1, "R3 masked pad_out");
    wr(A_MASK, 32'h0);

    // R4 alias write/read, mask bypass
    wr(A_ALIAS + 12'd20, 32'h1);
    rd(A_DOUT, 32'h0021, "R4 alias write");
    wr(A_MASK, 32'h0020);
    wr(A_ALIAS + 12'd20, 32'h0);
    rd(A_DOUT, 32'h0001, "R4 alias ignores mask");
    wr(A_MASK, 32'h0);
    set_pad(16'h0080);
    idle(3);
    rd(A_ALIAS + 12'd28, 32'h1, "R4 alias read pin7");
    rd(A_ALIAS + 12'd24, 32'h0, "R4 alias read pin6");

    // R12 pull-ups
    wr(A_PU, 32'h00FF);
    idle(1);
    chk({16'b0, pad_pu}, 32'h00FF, "R12 pad_pu");
    rd(A_LVL, 32'h0080, "R5 level read enabled");

    // R6 / R11 edges
    wr(A_CTL, 32'h1);
    ien = 32'h0500_0600;
    wr(A_IEN, ien);
    set_pad(16'h0180);
    idle(1);
    idle(1);
    chk({31'b0, irq}, 32'h0, "R11 irq not before third edge");
    idle(1);
    chk({31'b0, irq}, 32'h1, "R11 irq at third edge");
    rd(A_STAT, 32'h0100, "R6 rising pin8");
    wr(A_STAT, 32'h0100);
    chk({31'b0, irq}, 32'h0, "R9 irq drops with clear");
    rd(A_STAT, 32'h0, "R8 cleared");
    set_pad(16'h0080);
    idle(4);
    rd(A_STAT, 32'h0, "R6 falling ignored rise-only pin");
    set_pad(16'h0280);
    idle(4);
    rd(A_STAT, 32'h0, "R6 rising ignored fall-only pin");
    set_pad(16'h0080);
    idle(4);
    rd(A_STAT, 32'h0200, "R6 falling pin9");
    set_pad(16'h0480);
    idle(4);
    wr(A_STAT, 32'h0200);
    rd(A_STAT, 32'h0400, "R8 partial clear keeps pin10");
    chk({31'b0, irq}, 32'h1, "R9 irq with one flag");
    wr(A_STAT, 32'h0400);
    set_pad(16'h0080);
    idle(4);
    rd(A_STAT, 32'h0400, "R6 both edges falling pin10");
    wr(A_STAT, 32'h0400);

    // R7 level high on pin11
    wr(A_TYPE, 32'h0800);
    ien = ien | 32'h0800_0000;
    wr(A_IEN, ien);
    set_pad(16'h0880);
    idle(4);
    rd(A_STAT, 32'h0800, "R7 level high");
    wr(A_STAT, 32'h0800);
    rd(A_STAT, 32'h0800, "R8 clear loses to same-cycle event");
    set_pad(16'h0080);
    idle(4);
    wr(A_STAT, 32'h0800);
    rd(A_STAT, 32'h0, "R7 flag gone after level ends");

    // R7 level low on pin12
    wr(A_TYPE, 32'h1800);
    ien = ien | 32'h0000_1000;
    wr(A_IEN, ien);
    idle(2);
    rd(A_STAT, 32'h1000, "R7 level low");
    set_pad(16'h1080);
    idle(4);
    wr(A_STAT, 32'h1000);
    rd(A_STAT, 32'h0, "R7 low level ended");

    // R5 input disable pins 7 and 13
    wr(A_DIS, 32'h2080_0000);
    ien = ien | 32'h2000_0000;
    wr(A_IEN, ien);
    set_pad(16'h3080);
    idle(4);
    rd(A_LVL, 32'h1000, "R5 disabled pins read 0");
    rd(A_ALIAS + 12'd28, 32'h0, "R5 disabled alias read");
    rd(A_STAT, 32'h0, "R5 disabled pin no flag");
    rd(A_DIS, 32'h2080_0000, "R5 disable readback");

    // R10 gated detection
    wr(A_CTL, 32'h0);
    set_pad(16'h7080);
    idle(4);
    ien = ien | 32'h4000_0000;
    wr(A_IEN, ien);
    idle(3);
    rd(A_STAT, 32'h4000, "R10 gated history flags late enable");
    wr(A_STAT, 32'h4000);
    wr(A_CTL, 32'h1);
    set_pad(16'hF080);
    idle(4);
    ien = ien | 32'h8000_0000;
    wr(A_IEN, ien);
    idle(4);
    rd(A_STAT, 32'h0, "R10 always-on history no late flag");
    chk({31'b0, irq}, 32'h0, "R9 irq idle");

    idle(3);
    chk(exp_q.size(), 32'h0, "scoreboard drained");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule